// File: doc/BRIEF.md
# Backlight PWM Generator with Committed Settings

This block produces one pulse-width-modulated output for a display backlight. A prescaler divides the input clock. A period counter advances once per divided tick. The output is high while the period count is below a programmed high width. Software programs the block through a plain synchronous register write port, and it can read every register back combinationally.

The divider, period and high-width settings are double-buffered. Writes land in a working copy that has no effect on the waveform. Software releases the working copy by writing the commit bit to 1 and then to 0. The generator takes the new values at the end of the period that is running, so no period is ever produced from a mix of old and new settings. While the block is disabled there is no period running, so a commit takes effect at once. An enable bit starts the generator from count zero. Clearing the enable bit forces the output low.

Top module: `bl_pwm_top`

## Requirements
- R1: After reset, every register reads zero and `pwm_out` is low.
- R2: Register map (word address, bits). Address 0 holds the enable in bit 0. Address 1 holds the divider in bits [25:16]. Address 2 holds the period in bits [11:0] and the high width in bits [28:16]. Address 3 holds the commit bit in bit 0. Bits that are not listed are dropped on write and read as zero.
- R3: With divider d and period p active, the waveform repeats every (d+1)*(p+1) input clock cycles.
- R4: With high width h no greater than p+1, `pwm_out` is high for (d+1)*h cycles at the start of each period.
- R5: A high width of 0 keeps `pwm_out` low.
- R6: A high width of p+1 or more keeps `pwm_out` high for the whole period.
- R7: Writes to the divider, period or high-width registers do not change the waveform, and neither does writing 1 to the commit bit on its own. Only a commit write of 0 while the commit bit is 1 releases the working values. If the block is disabled at that point, they apply before the next enable.
- R8: A commit made while the generator runs takes effect at the next period boundary. The current period finishes with the old settings.
- R9: Clearing enable drives `pwm_out` low in the same cycle and returns both counters to zero. Setting it again starts a period at count zero, with the output high unless h is 0.
- R10: The largest divider value, 0x3FF, gives periods of 1024*(p+1) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, sampled on the rising clock edge |
| wr_addr | input | 2 | Word address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Word address of the read |
| rd_data | output | 32 | Combinational read data |
| pwm_out | output | 1 | PWM output |

## Verification
A wrong prescaler or period count shows up at `pwm_out` within one period. The high time or the period length drifts from (d+1)*h or (d+1)*(p+1), so the bench counts high cycles over whole-period windows and samples the first cycle of the following period. A commit that is applied too early or too late changes the number of high cycles in the remainder of the current period, and that is visible within the same period. A working copy that leaks through without a commit changes the duty cycle over any window of one period.

// File: rtl/bl_pwm_pkg.sv
// Package: widths, field positions and addresses shared by the PWM block.
// Assumes a 32-bit register bus with word addressing.
package bl_pwm_pkg;
    parameter int DIV_W  = 10;
    parameter int PER_W  = 12;
    parameter int HI_W   = 13;
    parameter int ADDR_W = 2;
    parameter int DATA_W = 32;

    localparam int EN_BIT     = 0;
    localparam int COMMIT_BIT = 0;
    localparam int DIV_LSB    = 16;
    localparam int PER_LSB    = 0;
    localparam int HI_LSB     = 16;

    localparam logic [ADDR_W-1:0] A_ENABLE = 2'd0;
    localparam logic [ADDR_W-1:0] A_DIV    = 2'd1;
    localparam logic [ADDR_W-1:0] A_SHAPE  = 2'd2;
    localparam logic [ADDR_W-1:0] A_COMMIT = 2'd3;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [PER_W-1:0] per;
        logic [HI_W-1:0]  hi;
    } pwm_cfg_t;
endpackage

// File: rtl/bl_pwm_regs.sv
// Register file: enable, working (shadow) settings, commit bit and the active copy.
// Assumes: the shadow copy moves to the active copy after a commit 1->0 write,
// either at a period boundary or at once while disabled.
module bl_pwm_regs
    import bl_pwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              period_end,
    output logic              en_o,
    output pwm_cfg_t          act_o
);
    logic     en_q;
    logic     commit_q;
    logic     pending_q;
    pwm_cfg_t shd_q;
    pwm_cfg_t act_q;
    logic     commit_fall;
    logic     load;
    logic     unused_wr_bits;

    assign unused_wr_bits = ^wr_data;
    assign commit_fall = wr_en && (wr_addr == A_COMMIT) && !wr_data[COMMIT_BIT] && commit_q;
    assign load        = pending_q && (period_end || !en_q);

    // Enable and commit control bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q     <= 1'b0;
            commit_q <= 1'b0;
        end else if (wr_en) begin
            if (wr_addr == A_ENABLE) en_q     <= wr_data[EN_BIT];
            if (wr_addr == A_COMMIT) commit_q <= wr_data[COMMIT_BIT];
        end
    end

    // Working copy of the settings, written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shd_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == A_DIV) shd_q.div <= wr_data[DIV_LSB +: DIV_W];
            if (wr_addr == A_SHAPE) begin
                shd_q.per <= wr_data[PER_LSB +: PER_W];
                shd_q.hi  <= wr_data[HI_LSB +: HI_W];
            end
        end
    end

    // Pending flag: set by a commit release, cleared once the active copy is loaded.
    always_ff @(posedge clk) begin
        if (!rst_n)           pending_q <= 1'b0;
        else if (commit_fall) pending_q <= 1'b1;
        else if (load)        pending_q <= 1'b0;
    end

    // Active copy seen by the generator.
    always_ff @(posedge clk) begin
        if (!rst_n)    act_q <= '0;
        else if (load) act_q <= shd_q;
    end

    // Read-back mux; unlisted bits are zero.
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_ENABLE: rd_data[EN_BIT] = en_q;
            A_DIV:    rd_data[DIV_LSB +: DIV_W] = shd_q.div;
            A_SHAPE: begin
                rd_data[PER_LSB +: PER_W] = shd_q.per;
                rd_data[HI_LSB +: HI_W]   = shd_q.hi;
            end
            default:  rd_data[COMMIT_BIT] = commit_q;
        endcase
    end

    assign en_o  = en_q;
    assign act_o = act_q;

    AST_ACT_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_q) |-> $past(period_end || !en_q)); // R8
    AST_NO_LOAD_WITHOUT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_q) |-> $past(pending_q)); // R7
endmodule

// File: rtl/bl_pwm_timebase.sv
// Timebase: a prescaler counting 0..div and a period counter counting 0..per.
// Assumes the limits change only when both counters are zero (boundary or idle).
module bl_pwm_timebase
    import bl_pwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div_lim,
    input  logic [PER_W-1:0] per_lim,
    output logic [PER_W-1:0] per_cnt,
    output logic             period_end
);
    logic [DIV_W-1:0] pre_q;
    logic [PER_W-1:0] per_q;
    logic             tick;

    assign tick       = (pre_q == div_lim);
    assign period_end = en && tick && (per_q == per_lim);

    // Prescaler and period counter; both held at zero while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            pre_q <= '0;
            per_q <= '0;
        end else if (tick) begin
            pre_q <= '0;
            per_q <= (per_q == per_lim) ? '0 : per_q + 1'b1;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    assign per_cnt = per_q;

    AST_PRE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> pre_q <= div_lim); // R3
    AST_PER_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> per_q <= per_lim); // R3
    AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (pre_q == '0) && (per_q == '0)); // R9
endmodule

// File: rtl/bl_pwm_compare.sv
// Output compare: high while enabled and the period count is below the high width.
// Assumes per_cnt never exceeds the active period limit.
module bl_pwm_compare
    import bl_pwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [PER_W-1:0] per_cnt,
    input  logic [HI_W-1:0]  hi,
    output logic             pwm
);
    localparam int CMP_W = (HI_W > PER_W) ? HI_W : PER_W;

    logic [CMP_W-1:0] cnt_ext;
    logic [CMP_W-1:0] hi_ext;

    // Widen both operands so a high width beyond the period compares correctly.
    always_comb begin
        cnt_ext = CMP_W'(per_cnt);
        hi_ext  = CMP_W'(hi);
        pwm     = en && (cnt_ext < hi_ext);
    end

    AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !pwm); // R9
    AST_ZERO_WIDTH_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (hi == '0) |-> !pwm); // R5
endmodule

// File: rtl/bl_pwm_top.sv
// Top: backlight PWM with double-buffered divider, period and high width.
// Assumes a single clock domain and synchronous active-low reset.
module bl_pwm_top
    import bl_pwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              pwm_out
);
    logic             en;
    logic             period_end;
    logic [PER_W-1:0] per_cnt;
    pwm_cfg_t         act;

    bl_pwm_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .period_end (period_end),
        .en_o       (en),
        .act_o      (act)
    );

    bl_pwm_timebase u_tb (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .div_lim    (act.div),
        .per_lim    (act.per),
        .per_cnt    (per_cnt),
        .period_end (period_end)
    );

    bl_pwm_compare u_cmp (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .per_cnt (per_cnt),
        .hi      (act.hi),
        .pwm     (pwm_out)
    );

    AST_FULL_WIDTH_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (en && ({1'b0, act.per} < act.hi)) |-> pwm_out); // R6
    AST_START_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(en) && (act.hi != '0)) |-> pwm_out); // R9
endmodule

// File: tb/bl_pwm_top_tb.sv
`timescale 1ns/1ps
module bl_pwm_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        pwm_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    bl_pwm_top dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .pwm_out(pwm_out)
    );

    localparam int NV = 7;
    localparam int T_D [NV] = '{0, 1, 2, 0, 3, 0, 1};
    localparam int T_P [NV] = '{3, 3, 4, 0, 2, 9, 5};
    localparam int T_H [NV] = '{2, 2, 0, 1, 5, 9, 6};

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    // Called at a negedge; the write lands at the next posedge; returns at the negedge after it.
    task automatic wr(logic [1:0] a, logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, logic [31:0] exp, string req);
        rd_addr = a;
        #0.5;
        chk(req, int'(rd_data), int'(exp));
    endtask

    // Counts high samples over n cycles, starting with the current negedge.
    task automatic meas(int n, output int cnt);
        cnt = 0;
        for (int i = 0; i < n; i++) begin
            if (pwm_out) cnt++;
            @(negedge clk);
        end
    endtask

    task automatic setup(int d, int p, int h);
        wr(2'd0, 32'h0);
        wr(2'd1, 32'(d) << 16);
        wr(2'd2, (32'(h) << 16) | 32'(p));
        wr(2'd3, 32'h1);
        wr(2'd3, 32'h0);
        wr(2'd0, 32'h1);
    endtask

    function automatic int hi_cycles(int d, int p, int h);
        return (d + 1) * ((h < p + 1) ? h : p + 1);
    endfunction

    initial begin
        int c;
        int per;
        int hx;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 pwm_out", int'(pwm_out), 0);
        for (int a = 0; a < 4; a++) rd(2'(a), 32'h0, "R1 reg");

        // R2: field positions, unlisted bits dropped
        wr(2'd1, 32'hFFFF_FFFF); rd(2'd1, 32'h03FF_0000, "R2 div reg");
        wr(2'd2, 32'hFFFF_FFFF); rd(2'd2, 32'h1FFF_0FFF, "R2 shape reg");
        wr(2'd3, 32'hFFFF_FFFF); rd(2'd3, 32'h0000_0001, "R2 commit reg");
        wr(2'd0, 32'hFFFF_FFFE); rd(2'd0, 32'h0000_0000, "R2 enable bit0");
        chk("R7 commit-1 alone keeps low", int'(pwm_out), 0);

        // R3 R4 R5 R6: table walk
        for (int i = 0; i < NV; i++) begin
            per = (T_D[i] + 1) * (T_P[i] + 1);
            hx  = hi_cycles(T_D[i], T_P[i], T_H[i]);
            setup(T_D[i], T_P[i], T_H[i]);
            chk("R9 first cycle after enable", int'(pwm_out), (T_H[i] != 0) ? 1 : 0);
            meas(per, c);
            chk((T_H[i] == 0) ? "R5 zero width" : (T_H[i] > T_P[i]) ? "R6 full width" : "R4 high time",
                c, hx);
            chk("R3 next period start", int'(pwm_out), (T_H[i] != 0) ? 1 : 0);
            meas(per, c);
            chk("R3 second period", c, hx);
        end

        // R10: largest divider
        setup(1023, 1, 1);
        meas(2048, c);
        chk("R10 max div high time", c, 1024);
        chk("R10 max div period start", int'(pwm_out), 1);
        meas(1, c);
        chk("R10 still high after start", c, 1);

        // R9: disable forces low, re-enable restarts at zero
        setup(0, 3, 2);
        meas(3, c);
        wr(2'd0, 32'h0);
        meas(6, c);
        chk("R9 disabled low", c, 0);
        wr(2'd0, 32'h1);
        chk("R9 restart high", int'(pwm_out), 1);
        meas(2, c);
        chk("R9 restart high count", c, 2);
        chk("R9 restart low phase", int'(pwm_out), 0);

        // R7: shadow writes and commit-1 alone do not change the waveform
        setup(0, 3, 2);
        wr(2'd2, (32'd4 << 16) | 32'd3);
        wr(2'd1, 32'd2 << 16);
        wr(2'd3, 32'h1);
        meas(8, c);
        chk("R7 no commit keeps duty", c, 4);
        rd(2'd2, 32'h0004_0003, "R7 shadow readback");
        wr(2'd1, 32'h0);
        wr(2'd3, 32'h0);
        repeat (8) @(negedge clk);
        meas(8, c);
        chk("R7 commit applies", c, 8);

        // R8: commit mid-period waits for the boundary
        setup(1, 3, 2);
        wr(2'd2, (32'd4 << 16) | 32'd3);
        wr(2'd3, 32'h1);
        wr(2'd3, 32'h0);
        meas(5, c);
        chk("R8 rest of current period", c, 1);
        meas(8, c);
        chk("R8 next period uses new width", c, 8);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule